// File: doc/BRIEF.md
# Gated Timer/Counter Pair

This block holds two timer/counter channels. Each channel has an 8-bit high byte and an 8-bit low byte. A shared 8-bit mode register gives each channel a 4-bit field. That field picks the count source: either a tick that fires once every 12 clocks, or falling edges on the channel's count pin. It also picks one of four operating modes and turns external gating on or off. When gating is on, the channel counts only while its gate pin is high. Software can then read the count to measure how long a pulse stayed high.

The modes are:
- a 13-bit counter;
- a full 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split mode, in which channel 0 becomes two independent 8-bit counters and channel 1 freezes.

Every overflow sets a sticky flag. The flag is visible on a port and through the register bus. Software reaches all state through a flat bus with address, write data, write enable and combinational read data.

Top module: `gtc_pair`

## Requirements
- R1: After reset, all eight readable addresses return 0x00, both run bits are 0, both flags are 0, and ovf_o is 0.
- R2: The register map is:
  - 0: mode register. Channel 0 uses bits [3:0] and channel 1 uses bits [7:4]. Each field is {gate, ext_src, mode[1:0]}, MSB first.
  - 1: control register. Bit 0 is run0, bit 1 is run1, bit 2 is flag0 and bit 3 is flag1. Bits [7:4] read as 0.
  - 2 and 3: channel 0 low and high byte.
  - 4 and 5: channel 1 low and high byte.
  - 6 and 7: read as 0x00, and writes to them have no effect.
- R3: When ext_src is 0, a channel advances by one on each internal tick. The tick fires on every 12th clock edge after reset.
- R4: When ext_src is 1, the count pin is registered on every clock and the registered value is registered once more. A falling edge is the older sample at 1 and the newer sample at 0. Each such edge advances the count by exactly one, on the following clock edge.
- R5: A channel advances only while its run bit is 1 and its gate bit is 0, or its run bit is 1 and its gate pin is high. Otherwise all of its count bytes hold.
- R6: Mode 0 counts the 13-bit value {high[7:0], low[4:0]}. Bits low[7:5] never change by counting. A wrap from 0x1FFF to 0 sets the channel flag.
- R7: Mode 1 counts the 16-bit value {high, low}. A wrap from 0xFFFF to 0 sets the flag.
- R8: Mode 2 increments the low byte only. When a step finds the low byte at 0xFF, the low byte loads the high byte, the high byte stays unchanged, and the flag is set.
- R9: Overflow sets a flag in hardware. A write to address 1 loads the flags from bits [3:2]. If a hardware set and a software write of 0 fall in the same cycle, the flag ends at 1.
- R10: Clearing and then setting a run bit leaves the count registers unchanged. Counting resumes from the held value.
- R11: Mode 3 behaves as follows:
  - Channel 1 in mode 3 holds its count.
  - Channel 0 in mode 3 counts its low byte as an 8-bit counter under its own source and gating. The low byte's wrap sets flag0.
  - In the same case, channel 0's high byte counts ticks whenever run1 is 1, and its wrap sets flag1. Channel 1's own overflow then does not set flag1.
- R12: A bus write to a count byte takes precedence over counting for that byte in the same cycle. Any carry or flag from that cycle's step is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| cnt_pin_i | input | 2 | External count pins, bit i for channel i |
| gate_pin_i | input | 2 | External gate pins, bit i for channel i |
| ovf_o | output | 2 | Overflow flags, bit i for channel i |

## Verification
Two functions can fall in the same cycle:
- a hardware overflow set and a software write that clears the flag;
- a bus write to a count byte and a counting step on that byte.

The bench reads its own reference model's prescaler phase, then places a control write of zero flags on the exact edge where a mode 2 reload occurs. It expects the flag to read 1 afterwards. The low byte of a channel that is counting external edges is also rewritten on every cycle. The written value must stick while the carry into the high byte still takes effect. Random register writes against a random pin activity create many more such overlaps, and each one is compared against the reference model.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } mode_e;

  typedef struct packed {
    logic  gate;
    logic  ext_src;
    mode_e mode;
  } chan_cfg_t;

  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_CTRL = 3'd1;
  localparam logic [AW-1:0] A_LO0  = 3'd2;
  localparam logic [AW-1:0] A_HI0  = 3'd3;
  localparam logic [AW-1:0] A_LO1  = 3'd4;
  localparam logic [AW-1:0] A_HI1  = 3'd5;
endpackage

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/gtc_edge.sv
module gtc_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign fall_o = s2_q & ~s1_q;
endmodule

// File: rtl/gtc_chan.sv
module gtc_chan
  import gtc_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned M0_LO    = 5,
  parameter bit          SPLIT_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  chan_cfg_t     cfg_i,
  input  logic          step_i,
  input  logic          split_step_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          ovf_o,
  output logic          split_ovf_o
);
  localparam int unsigned W13 = DW + M0_LO;

  logic [DW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [W13:0]  s13;
  logic [2*DW:0] s16;
  logic [DW:0]   s_lo, s_hi;

  always_comb begin
    s13  = {1'b0, hi_q, lo_q[M0_LO-1:0]} + (W13+1)'(1);
    s16  = {1'b0, hi_q, lo_q} + (2*DW+1)'(1);
    s_lo = {1'b0, lo_q} + (DW+1)'(1);
    s_hi = {1'b0, hi_q} + (DW+1)'(1);
    lo_n = lo_q;
    hi_n = hi_q;
    ovf_o = 1'b0;
    split_ovf_o = 1'b0;
    unique case (cfg_i.mode)
      MODE_13: if (step_i) begin
        lo_n[M0_LO-1:0] = s13[M0_LO-1:0];
        hi_n            = s13[W13-1:M0_LO];
        ovf_o           = s13[W13];
      end
      MODE_16: if (step_i) begin
        {ovf_o, hi_n, lo_n} = s16;
      end
      MODE_RELOAD: if (step_i) begin
        if (&lo_q) begin
          lo_n  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_n = s_lo[DW-1:0];
        end
      end
      MODE_SPLIT: if (SPLIT_EN) begin
        if (step_i)       {ovf_o, lo_n} = s_lo;
        if (split_step_i) {split_ovf_o, hi_n} = s_hi;
      end
      default: ;
    endcase
    // bus write beats the count for the written byte
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/gtc_pair.sv
module gtc_pair
  import gtc_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned PRESCALE = 12,
  parameter int unsigned M0_LO    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  input  logic [1:0]    cnt_pin_i,
  input  logic [1:0]    gate_pin_i,
  output logic [1:0]    ovf_o
);
  localparam int unsigned NCH = 2;
  localparam int unsigned FW  = 4;

  logic [NCH*FW-1:0]       tmod_q;
  logic [NCH-1:0]          run_q, flag_q, hw_set_w;
  logic [NCH-1:0]          fall_w, step_w, ovf_w, sovf_w;
  logic [NCH-1:0][DW-1:0]  lo_w, hi_w;
  logic                    tick_w, ctrl_we, split_w;
  chan_cfg_t               cfg_w [NCH];

  assign ctrl_we = we_i && (addr_i == A_CTRL);

  gtc_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick_w)
  );

  gtc_edge #(.N(NCH)) u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (cnt_pin_i), .fall_o (fall_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmod_q <= '0;
      run_q  <= '0;
    end else begin
      if (we_i && addr_i == A_MODE) tmod_q <= wdata_i[NCH*FW-1:0];
      if (ctrl_we)                  run_q  <= wdata_i[NCH-1:0];
    end
  end

  assign split_w = (cfg_w[0].mode == MODE_SPLIT);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic en;
    assign cfg_w[i] = chan_cfg_t'(tmod_q[FW*i +: FW]);
    assign en        = run_q[i] & (~cfg_w[i].gate | gate_pin_i[i]);
    assign step_w[i] = en & (cfg_w[i].ext_src ? fall_w[i] : tick_w);

    gtc_chan #(.DW(DW), .M0_LO(M0_LO), .SPLIT_EN(i == 0)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cfg_i        (cfg_w[i]),
      .step_i       (step_w[i]),
      .split_step_i ((i == 0) ? (tick_w & run_q[1]) : 1'b0),
      .wr_lo_i      (we_i && addr_i == AW'(A_LO0 + 2*i)),
      .wr_hi_i      (we_i && addr_i == AW'(A_HI0 + 2*i)),
      .wdata_i      (wdata_i),
      .lo_o         (lo_w[i]),
      .hi_o         (hi_w[i]),
      .ovf_o        (ovf_w[i]),
      .split_ovf_o  (sovf_w[i])
    );

    if (i == 1) begin : g_set1
      assign hw_set_w[i] = split_w ? sovf_w[0] : ovf_w[i];
    end else begin : g_set0
      assign hw_set_w[i] = ovf_w[i];
    end

    // hardware set outranks a software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q[i] <= 1'b0;
      else if (hw_set_w[i]) flag_q[i] <= 1'b1;
      else if (ctrl_we)     flag_q[i] <= wdata_i[NCH+i];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = DW'(tmod_q);
      A_CTRL:  rdata_o = DW'({flag_q, run_q});
      A_LO0:   rdata_o = lo_w[0];
      A_HI0:   rdata_o = hi_w[0];
      A_LO1:   rdata_o = lo_w[1];
      A_HI1:   rdata_o = hi_w[1];
      default: rdata_o = '0;
    endcase
  end

  assign ovf_o = flag_q;
endmodule

// File: rtl/gtc_pair_chk.sv
module gtc_pair_chk
  import gtc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          tick_i,
  input logic [1:0]    fall_i,
  input logic [1:0]    hw_set_i,
  input logic [1:0]    flag_i,
  input logic [1:0]    run_i,
  input logic [7:0]    tmod_i,
  input logic [DW-1:0] lo0_i,
  input logic [DW-1:0] hi0_i,
  input logic [DW-1:0] lo1_i,
  input logic [DW-1:0] hi1_i
);
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i); // R3

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i[0] |=> !fall_i[0]); // R4

  AST_SET_WINS0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i[0] |=> flag_i[0]); // R9

  AST_SET_WINS1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i[1] |=> flag_i[1]); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i[0] && !(we_i && addr_i == A_CTRL)) |=> flag_i[0]); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i[0] && tmod_i[1:0] != 2'd3 && !(we_i && (addr_i == A_LO0 || addr_i == A_HI0)))
    |=> ($stable(lo0_i) && $stable(hi0_i))); // R5

  AST_MODE0_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmod_i[1:0] == 2'd0 && !(we_i && addr_i == A_LO0))
    |=> (lo0_i[7:5] == $past(lo0_i[7:5]))); // R6

  AST_SPLIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmod_i[5:4] == 2'd3 && !(we_i && (addr_i == A_LO1 || addr_i == A_HI1)))
    |=> ($stable(lo1_i) && $stable(hi1_i))); // R11
endmodule

bind gtc_pair gtc_pair_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .tick_i   (tick_w),
  .fall_i   (fall_w),
  .hw_set_i (hw_set_w),
  .flag_i   (flag_q),
  .run_i    (run_q),
  .tmod_i   (tmod_q),
  .lo0_i    (lo_w[0]),
  .hi0_i    (hi_w[0]),
  .lo1_i    (lo_w[1]),
  .hi1_i    (hi_w[1])
);

// File: tb/gtc_pair_test.sv
module gtc_pair_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] ovf;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gtc_pair uut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wdata_i (wdata), .we_i (we),
    .rdata_o (rdata), .cnt_pin_i (cnt_pin), .gate_pin_i (gate_pin), .ovf_o (ovf)
  );

  // reference model
  logic [7:0] m_tmod = '0;
  logic [1:0] m_run = '0, m_flag = '0, m_s1 = '0, m_s2 = '0;
  logic [7:0] m_tl [2] = '{8'h0, 8'h0};
  logic [7:0] m_th [2] = '{8'h0, 8'h0};
  int         m_pre = 0;

  task automatic model_edge();
    logic tick, en, stp, sev;
    logic [1:0] fall, ev, set;
    logic [3:0] f;
    logic [7:0] ntl [2];
    logic [7:0] nth [2];
    logic [13:0] s13;
    logic [16:0] s16;
    logic [8:0] s9;
    tick = (m_pre == 11);
    fall = m_s2 & ~m_s1;
    ev = '0; sev = 1'b0;
    for (int i = 0; i < 2; i++) begin
      ntl[i] = m_tl[i]; nth[i] = m_th[i];
      f = m_tmod[4*i +: 4];
      en = m_run[i] & (!f[3] | gate_pin[i]);
      stp = en & (f[2] ? fall[i] : tick);
      case (f[1:0])
        2'd0: if (stp) begin
          s13 = {1'b0, m_th[i], m_tl[i][4:0]} + 14'd1;
          ntl[i][4:0] = s13[4:0]; nth[i] = s13[12:5]; ev[i] = s13[13];
        end
        2'd1: if (stp) begin
          s16 = {1'b0, m_th[i], m_tl[i]} + 17'd1;
          {ev[i], nth[i], ntl[i]} = s16;
        end
        2'd2: if (stp) begin
          if (m_tl[i] == 8'hFF) begin ntl[i] = m_th[i]; ev[i] = 1'b1; end
          else ntl[i] = m_tl[i] + 8'd1;
        end
        default: if (i == 0) begin
          if (stp) begin s9 = {1'b0, m_tl[0]} + 9'd1; {ev[0], ntl[0]} = s9; end
          if (tick && m_run[1]) begin s9 = {1'b0, m_th[0]} + 9'd1; {sev, nth[0]} = s9; end
        end
      endcase
    end
    set[0] = ev[0];
    set[1] = (m_tmod[1:0] == 2'd3) ? sev : ev[1];
    if (we) begin
      case (addr)
        3'd2: ntl[0] = wdata;
        3'd3: nth[0] = wdata;
        3'd4: ntl[1] = wdata;
        3'd5: nth[1] = wdata;
        default: ;
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      if (set[i]) m_flag[i] = 1'b1;
      else if (we && addr == 3'd1) m_flag[i] = wdata[2+i];
      m_tl[i] = ntl[i]; m_th[i] = nth[i];
    end
    if (we && addr == 3'd0) m_tmod = wdata;
    if (we && addr == 3'd1) m_run = wdata[1:0];
    m_pre = tick ? 0 : m_pre + 1;
    m_s2 = m_s1; m_s1 = cnt_pin;
  endtask

  always @(posedge clk) if (rst_n) model_edge();

  function automatic logic [7:0] model_read(int a);
    case (a)
      0: return m_tmod;
      1: return {4'h0, m_flag, m_run};
      2: return m_tl[0];
      3: return m_th[0];
      4: return m_tl[1];
      5: return m_th[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic expect8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic read_at(int a, output logic [7:0] v);
    addr = 3'(a);
    #1;
    v = rdata;
  endtask

  // called right after a negedge with we low
  task automatic check_all(string tag);
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      read_at(a, v);
      expect8(tag, $sformatf("addr%0d", a), v, model_read(a));
    end
    expect8(tag, "ovf_o", {6'b0, ovf}, {6'b0, m_flag});
  endtask

  task automatic cyc(bit w, logic [2:0] a, logic [7:0] d, logic [1:0] cp, logic [1:0] gp, string tag);
    @(negedge clk);
    we = 1'b0;
    check_all(tag);
    we = w; addr = a; wdata = d; cnt_pin = cp; gate_pin = gp;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
    cyc(1'b1, a, d, cnt_pin, gate_pin, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, 3'd0, 8'h00, cnt_pin, gate_pin, tag);
  endtask

  task automatic pulses(int n, string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, 3'd0, 8'h00, {1'b0, k[0]} | {k[0], 1'b0}, gate_pin, tag);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, explicit constants
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      read_at(a, v);
      expect8("R1", $sformatf("reset addr%0d", a), v, 8'h00);
    end
    expect8("R1", "reset ovf_o", {6'b0, ovf}, 8'h00);

    // R2: map readback
    wr(3'd0, 8'hA5, "R2"); idle(1, "R2");
    @(negedge clk); read_at(0, v); expect8("R2", "mode readback", v, 8'hA5);
    wr(3'd6, 8'h5A, "R2"); wr(3'd7, 8'hFF, "R2");
    wr(3'd0, 8'h00, "R2"); idle(2, "R2");

    // R3: timer source, free-running tick
    wr(3'd2, 8'h00, "R3"); wr(3'd1, 8'h01, "R3"); idle(60, "R3");

    // R6: 13-bit wrap, upper low bits preserved
    wr(3'd1, 8'h00, "R6");
    wr(3'd2, 8'hFE, "R6"); wr(3'd3, 8'hFF, "R6");
    wr(3'd1, 8'h01, "R6");
    while (m_flag[0] !== 1'b1) idle(1, "R6");
    @(negedge clk); read_at(2, v); expect8("R6", "low after wrap", v, 8'hE0);
    read_at(3, v); expect8("R6", "high after wrap", v, 8'h00);
    idle(30, "R6");

    // R4: counter source on falling edges
    wr(3'd1, 8'h00, "R4"); wr(3'd0, 8'h45, "R4");
    wr(3'd2, 8'h00, "R4"); wr(3'd3, 8'h00, "R4"); wr(3'd1, 8'h03, "R4");
    pulses(40, "R4");
    cyc(1'b0, 3'd0, 8'h00, 2'b11, 2'b00, "R4"); idle(4, "R4");
    cyc(1'b0, 3'd0, 8'h00, 2'b00, 2'b00, "R4"); idle(4, "R4");

    // R7: 16-bit wrap
    wr(3'd1, 8'h00, "R7"); wr(3'd2, 8'hF8, "R7"); wr(3'd3, 8'hFF, "R7");
    wr(3'd1, 8'h01, "R7"); pulses(30, "R7");

    // R8: reload mode
    wr(3'd1, 8'h00, "R8"); wr(3'd0, 8'h66, "R8");
    wr(3'd2, 8'hFA, "R8"); wr(3'd3, 8'hFC, "R8");
    wr(3'd4, 8'hFE, "R8"); wr(3'd5, 8'h80, "R8");
    wr(3'd1, 8'h03, "R8"); pulses(40, "R8");

    // R5: gating by pin level
    wr(3'd1, 8'h00, "R5"); wr(3'd0, 8'h88, "R5");
    for (int k = 0; k < 8; k++) begin
      gate_pin = k[0] ? 2'b11 : 2'b00;
      wr(3'd1, k[1] ? 8'h03 : 8'h00, "R5");
      idle(30, "R5");
    end

    // R10: stop then resume keeps the count
    wr(3'd0, 8'h11, "R10"); wr(3'd1, 8'h03, "R10"); idle(50, "R10");
    wr(3'd1, 8'h00, "R10"); idle(40, "R10");
    wr(3'd1, 8'h03, "R10"); idle(50, "R10");

    // R11: split mode, channel 1 frozen
    wr(3'd0, 8'h33, "R11"); wr(3'd2, 8'hF0, "R11"); wr(3'd3, 8'hF8, "R11");
    wr(3'd1, 8'h03, "R11"); idle(150, "R11");
    wr(3'd0, 8'h13, "R11"); wr(3'd1, 8'h02, "R11"); idle(120, "R11");

    // R12: count-byte writes racing counting
    wr(3'd1, 8'h00, "R12"); wr(3'd0, 8'h05, "R12"); wr(3'd1, 8'h01, "R12");
    for (int k = 0; k < 20; k++) cyc(1'b1, 3'd2, 8'hFF, {1'b0, k[0]}, 2'b00, "R12");
    idle(3, "R12");

    // R9: software clear in the exact reload cycle
    wr(3'd1, 8'h00, "R9"); wr(3'd0, 8'h02, "R9");
    wr(3'd2, 8'hFF, "R9"); wr(3'd3, 8'h10, "R9");
    wr(3'd1, 8'h0C, "R9"); idle(1, "R9");
    wr(3'd1, 8'h01, "R9");
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      while (m_pre != 11) begin @(negedge clk); end
      we = 1'b0; addr = 3'd2; #1;
      if (rdata == 8'hFF) begin
        we = 1'b1; addr = 3'd1; wdata = 8'h01;
        @(negedge clk); we = 1'b0;
        read_at(1, v); expect8("R9", "set beats clear", v & 8'h04, 8'h04);
        wr(3'd2, 8'hFF, "R9");
      end else begin
        wr(3'd2, 8'hFF, "R9");
      end
    end
    idle(5, "R9");

    // randomized mix, many set/clear and write/count overlaps (R9, R12)
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)
        cyc(1'b1, r[6:4], r[15:8], r[17:16], r[19:18], "R9");
      else
        cyc(1'b0, 3'd0, 8'h00, r[17:16], r[19:18], "R12");
    end

    @(negedge clk); we = 1'b0; check_all("R12");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule